// File: doc/BRIEF.md
# Faulting Instruction Capture Registers

This block keeps two read-only 32-bit system-coprocessor registers for a core with branch delay slots. When the core takes an exception, the first register takes the instruction word that caused it. The second register takes the branch word just before it, but only when the faulting instruction sits in a delay slot. Fault handlers read both registers through a coprocessor register/select port. This lets a handler decode or emulate the offending instruction without fetching it again.

Capture depends on the exception cause code. Some causes always record the word. Load-side TLB and address faults record it only when a real instruction word exists; a fault during the fetch itself, including a misaligned fetch address, leaves no word to record. All other causes never record. Nothing is captured while the exception-level bit is already set, or while the core runs its compact 16-bit encoding. Each register has its own configuration enable. When an enable is clear, that register neither captures nor reads back, and a read of it is flagged as unimplemented.

Top module: `fault_insn_capture`

## Requirements
- R1: After reset, both registers hold zero. Reads of register 8 select 1 and select 2, with both enables set, return 0.
- R2: On an exception strobe with cause 3, 5, 8, 9, 10, 11, 12, 13, 15 or 19, the faulting word is stored when three conditions hold: the exception-level bit is clear, the core is not in compact mode, and the fault enable is set. A later read of register 8 select 1 returns the stored word.
- R3: The prior-branch register (register 8 select 2) stores the preceding word only when all of these hold: a capture occurs, the delay-slot flag is set, and the prior enable is set. Otherwise it keeps its value.
- R4: An exception strobe while the exception-level bit is set changes neither register.
- R5: Causes 1, 2 and 4 capture only when the instruction-word-available flag is 1. With the flag at 0 (a fetch fault or a misaligned fetch), neither register changes.
- R6: All other cause codes, including 6, 18 and 20, change neither register.
- R7: An exception strobe while compact mode is set changes neither register.
- R8: A read of select 1 while the fault enable is clear, or of select 2 while the prior enable is clear, returns 0 with rd_unimpl set to 1. A clear enable also prevents that register from capturing.
- R9: Writes to register 8 selects 0, 1 and 2 are ignored. Neither register changes, and acc_illegal stays 0.
- R10: A read or write of register 8 with select 3 to 7 sets acc_illegal to 1, with rd_data 0 and rd_unimpl 0. An access to any other register number, or a read of select 0, sets none of these outputs.
- R11: A capture takes effect at the clock edge where the strobe is sampled. A read in that same cycle returns the old value, and the new value is readable from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception taken this cycle |
| exc_cause | input | 5 | Exception cause code |
| insn_avail | input | 1 | A valid instruction word exists for this exception |
| in_delay_slot | input | 1 | Faulting instruction is in a branch delay slot |
| exl | input | 1 | Exception-level status bit |
| compact_mode | input | 1 | Core runs the 16-bit compact encoding |
| fault_word | input | 32 | Instruction word at the faulting PC |
| prior_word | input | 32 | Instruction word at the faulting PC minus 4 |
| cfg_fault_en | input | 1 | Enable for the faulting-instruction register (configuration bit 26) |
| cfg_prior_en | input | 1 | Enable for the prior-branch register (configuration bit 27) |
| acc_reg | input | 5 | Coprocessor register number of the access |
| acc_sel | input | 3 | Select field of the access |
| rd_en | input | 1 | Read access |
| wr_en | input | 1 | Write access |
| rd_data | output | 32 | Read data (combinational) |
| rd_unimpl | output | 1 | Read of a register whose enable is clear |
| acc_illegal | output | 1 | Access to an undefined select of register 8 |

## Verification
A capture shows one cycle after the strobe. The bench drives each exception at a falling edge and reads select 1 in the same cycle, which checks that the old value is still returned. It then reads both selects at the next falling edges, after the capturing rising edge. Read results are combinational, so the bench samples them 1 ns after it drives the access, which is still before the next rising edge. The bench sweeps every cause code against the word-available flag, the delay-slot flag, the exception-level bit and compact mode. Expected contents come from a register model kept in the bench.

// File: rtl/fault_insn_capture.sv
module fault_insn_capture #(
  parameter int XLEN     = 32,
  parameter int CAUSE_W  = 5,
  parameter int REG_W    = 5,
  parameter int SEL_W    = 3,
  parameter int HOME_REG = 8,
  parameter logic [(1<<CAUSE_W)-1:0] ALWAYS_MASK = 'h0008_BF28,
  parameter logic [(1<<CAUSE_W)-1:0] COND_MASK   = 'h0000_0016
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               insn_avail,
  input  logic               in_delay_slot,
  input  logic               exl,
  input  logic               compact_mode,
  input  logic [XLEN-1:0]    fault_word,
  input  logic [XLEN-1:0]    prior_word,
  input  logic               cfg_fault_en,
  input  logic               cfg_prior_en,
  input  logic [REG_W-1:0]   acc_reg,
  input  logic [SEL_W-1:0]   acc_sel,
  input  logic               rd_en,
  input  logic               wr_en,
  output logic [XLEN-1:0]    rd_data,
  output logic               rd_unimpl,
  output logic               acc_illegal
);
  localparam logic [REG_W-1:0] HOME = REG_W'(HOME_REG);
  localparam logic [SEL_W-1:0] SEL_FAULT = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_PRIOR = SEL_W'(2);

  logic [XLEN-1:0] fault_q, prior_q;

  wire want = ALWAYS_MASK[exc_cause] | (COND_MASK[exc_cause] & insn_avail);
  wire take = exc_valid & ~exl & ~compact_mode & want;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= '0;
      prior_q <= '0;
    end else if (take) begin
      if (cfg_fault_en) fault_q <= fault_word;
      if (cfg_prior_en && in_delay_slot) prior_q <= prior_word;
    end
  end

  wire home   = acc_reg == HOME;
  wire at_flt = home && acc_sel == SEL_FAULT;
  wire at_pri = home && acc_sel == SEL_PRIOR;

  always_comb begin
    rd_data = '0;
    if (rd_en && at_flt && cfg_fault_en) rd_data = fault_q;
    if (rd_en && at_pri && cfg_prior_en) rd_data = prior_q;
  end

  assign rd_unimpl   = rd_en && ((at_flt && !cfg_fault_en) || (at_pri && !cfg_prior_en));
  assign acc_illegal = (rd_en || wr_en) && home && acc_sel > SEL_PRIOR;
endmodule

module fault_insn_capture_chk #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               exc_valid,
  input logic [CAUSE_W-1:0] exc_cause,
  input logic               in_delay_slot,
  input logic               exl,
  input logic               compact_mode,
  input logic               cfg_fault_en,
  input logic [XLEN-1:0]    fault_q,
  input logic [XLEN-1:0]    prior_q,
  input logic [XLEN-1:0]    rd_data,
  input logic               rd_unimpl,
  input logic               acc_illegal
);
  a_r4_exl_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exl) |=> ($stable(fault_q) && $stable(prior_q)));

  a_r3_slot_only: assert property (@(posedge clk) disable iff (!rst_n)
    !in_delay_slot |=> $stable(prior_q));

  a_r6_never_causes: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_cause == CAUSE_W'(6) || exc_cause == CAUSE_W'(18) || exc_cause == CAUSE_W'(20))
      |=> ($stable(fault_q) && $stable(prior_q)));

  a_r7_compact_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    compact_mode |=> ($stable(fault_q) && $stable(prior_q)));

  a_r8_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_fault_en |=> $stable(fault_q));

  a_r8_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unimpl |-> rd_data == '0);

  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    acc_illegal |-> (rd_data == '0 && !rd_unimpl));
endmodule

bind fault_insn_capture fault_insn_capture_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
  .in_delay_slot(in_delay_slot), .exl(exl), .compact_mode(compact_mode),
  .cfg_fault_en(cfg_fault_en), .fault_q(fault_q), .prior_q(prior_q),
  .rd_data(rd_data), .rd_unimpl(rd_unimpl), .acc_illegal(acc_illegal)
);

// File: tb/fault_insn_capture_test.sv
`timescale 1ns/100ps
module fault_insn_capture_test;
  logic clk = 0, rst_n = 0;
  logic exc_valid = 0, insn_avail = 0, in_delay_slot = 0, exl = 0, compact_mode = 0;
  logic [4:0] exc_cause = 0;
  logic [31:0] fault_word = 0, prior_word = 0;
  logic cfg_fault_en = 1, cfg_prior_en = 1;
  logic [4:0] acc_reg = 0;
  logic [2:0] acc_sel = 0;
  logic rd_en = 0, wr_en = 0;
  logic [31:0] rd_data;
  logic rd_unimpl, acc_illegal;

  int checks = 0, fails = 0, serial = 0;
  logic [31:0] m_fault = 0, m_prior = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fault_insn_capture uut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .insn_avail(insn_avail), .in_delay_slot(in_delay_slot), .exl(exl),
    .compact_mode(compact_mode), .fault_word(fault_word), .prior_word(prior_word),
    .cfg_fault_en(cfg_fault_en), .cfg_prior_en(cfg_prior_en), .acc_reg(acc_reg),
    .acc_sel(acc_sel), .rd_en(rd_en), .wr_en(wr_en), .rd_data(rd_data),
    .rd_unimpl(rd_unimpl), .acc_illegal(acc_illegal));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic bit wants(int cause, bit avail);
    if (cause inside {3, 5, 8, 9, 10, 11, 12, 13, 15, 19}) return 1;
    if (cause inside {1, 2, 4}) return avail;
    return 0;
  endfunction

  task automatic access(int rnum, int sel, bit rd, bit wr, string req,
                        logic [31:0] ed, bit eu, bit ei);
    @(negedge clk);
    exc_valid = 0;
    acc_reg = rnum[4:0]; acc_sel = sel[2:0]; rd_en = rd; wr_en = wr;
    #1;
    check(req, rd_data, ed);
    check(req, {31'b0, rd_unimpl}, {31'b0, eu});
    check(req, {31'b0, acc_illegal}, {31'b0, ei});
    rd_en = 0; wr_en = 0;
  endtask

  task automatic read_both(string req);
    access(8, 1, 1, 0, req, cfg_fault_en ? m_fault : 32'h0, !cfg_fault_en, 0);
    access(8, 2, 1, 0, req, cfg_prior_en ? m_prior : 32'h0, !cfg_prior_en, 0);
  endtask

  task automatic raise(int cause, bit avail, bit ds, bit lvl, bit cm, string req);
    @(negedge clk);
    serial++;
    exc_valid = 1; exc_cause = cause[4:0]; insn_avail = avail; in_delay_slot = ds;
    exl = lvl; compact_mode = cm;
    fault_word = 32'hF000_0000 ^ (serial * 32'h0001_0003);
    prior_word = 32'h0B00_0000 ^ (serial * 32'h0000_0107);
    acc_reg = 8; acc_sel = 1; rd_en = 1; wr_en = 0;
    #1;
    check("R11 same-cycle read", rd_data, cfg_fault_en ? m_fault : 32'h0);
    @(posedge clk);
    if (!lvl && !cm && wants(cause, avail)) begin
      if (cfg_fault_en) m_fault = fault_word;
      if (cfg_prior_en && ds) m_prior = prior_word;
    end
    read_both(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    access(8, 1, 1, 0, "R1 reset fault reg", 0, 0, 0);
    access(8, 2, 1, 0, "R1 reset prior reg", 0, 0, 0);

    for (int c = 0; c < 32; c++)
      for (int a = 0; a < 2; a++)
        for (int d = 0; d < 2; d++)
          for (int m = 0; m < 4; m++)
            raise(c, a[0], d[0], m[0], m[1],
                  (m != 0) ? "R4/R7 blocked" :
                  (c inside {1, 2, 4}) ? "R5 conditional cause" :
                  wants(c, 1) ? "R2/R3 capture" : "R6 never cause");

    for (int f = 0; f < 2; f++)
      for (int p = 0; p < 2; p++) begin
        cfg_fault_en = f[0]; cfg_prior_en = p[0];
        raise(9, 1, 1, 0, 0, "R8 enable gating");
        raise(12, 1, 0, 0, 0, "R3 no slot");
      end
    cfg_fault_en = 1; cfg_prior_en = 1;
    read_both("R8 re-enabled read");

    for (int s = 0; s < 3; s++) begin
      access(8, s, 0, 1, "R9 write ignored", 0, 0, 0);
      read_both("R9 after write");
    end
    for (int s = 3; s < 8; s++) begin
      access(8, s, 1, 0, "R10 illegal read", 0, 0, 1);
      access(8, s, 0, 1, "R10 illegal write", 0, 0, 1);
    end
    access(9, 1, 1, 1, "R10 other register", 0, 0, 0);
    access(8, 0, 1, 0, "R10 select 0", 0, 0, 0);

    raise(4, 0, 1, 0, 0, "R5 misaligned fetch");
    raise(19, 1, 1, 0, 0, "R2 read-inhibit");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule